// File: doc/BRIEF.md
# Byte-Indexed Word Memory Access Unit

This unit lets a processor treat a memory of 16-bit words as an array of 8-bit bytes. The caller gives two operands, an operation and, for a store, one data byte. One operand is the word address of the array's first word. The other is a signed byte index. A swap input sets which operand plays which role. The unit turns the index into a word offset and a byte lane. A load returns the chosen byte zero-extended. A store reads the containing word, replaces one half, and writes the word back.

The unit drives one synchronous memory port. A read returns its data one cycle after the read strobe. A write takes effect on the clock edge where the write strobe is high. The unit runs one operation at a time. `busy` is high while an operation is in flight. `done` pulses for one cycle when a load result is on `load_data` or when a store's write is on the port.

Top module: `byte_access_unit`

## Requirements
- R1: The word address is base + (index >>> 1), with the index taken as a signed 16-bit value and the sum wrapping modulo 2^16. A negative index therefore reaches words below the base.
- R2: Bit 0 of the index picks the byte lane. A value of 0 (even) selects word bits 15:8, and a value of 1 (odd) selects word bits 7:0.
- R3: A load presents the selected byte on `load_data[7:0]` with `load_data[15:8]` equal to zero. This happens in the cycle where `done` is high.
- R4: A store writes back a word whose selected lane holds `wr_byte` and whose other lane holds the previously stored value.
- R5: With `swap_ops`=0, `opnd_a` is the base and `opnd_b` is the index. With `swap_ops`=1 the two roles are exchanged.
- R6: For a load accepted on clock edge k, `mem_re` is high in the cycle after edge k. `done` is high one cycle after that, and the load takes three cycles from start to completion.
- R7: For a store, the cycle after the read data returns has neither `mem_re` nor `mem_we` high. `mem_we` is then high, together with `done`, in the fourth cycle after acceptance. `mem_re` and `mem_we` are never high together.
- R8: `start` is ignored while `busy` is high. A start pulse during an operation alters neither that operation nor launches a further one.
- R9: After reset the unit is idle, with `busy`, `done`, `mem_re` and `mem_we` all low. `done` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an operation (taken only when idle) |
| op_store | input | 1 | 1 = store byte, 0 = load byte |
| swap_ops | input | 1 | Exchange base and index roles of the operands |
| opnd_a | input | 16 | Operand A (base when not swapped) |
| opnd_b | input | 16 | Operand B (signed byte index when not swapped) |
| wr_byte | input | 8 | Byte to deposit on a store |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| load_data | output | 16 | Loaded byte, zero-extended, valid with done |
| mem_addr | output | 16 | Memory word address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Word to write |
| mem_rdata | input | 16 | Read data, one cycle after mem_re |

## Verification
The bench sweeps signed indices across zero under both swap settings, so it targets the arithmetic halving of negative indices. A design that shifted logically would jump about 32K words away, and one that rounded toward zero would hit the wrong word for odd negative indices. It also drives addresses that wrap past 0xFFFF and 0x0000, which a design with truncated or unsigned sums would miss. Every store is followed by a reload of both lanes, so swapped lanes, a clobbered neighbouring byte, or a missing idle cycle between read and write all show up as wrong data or wrong strobe timing. A start pulse is also injected mid-operation, where a design that re-accepts it would corrupt the address or issue a second access.

// File: rtl/bau_pkg.sv
package bau_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = WORD_W / 2;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_READ = 3'd1,
    ST_DATA = 3'd2,
    ST_GAP  = 3'd3,
    ST_WRITE = 3'd4
  } bau_state_t;

  // Word address reached by a signed byte index from a base word address.
  function automatic logic [WORD_W-1:0] word_of(input logic [WORD_W-1:0] base,
                                                 input logic [WORD_W-1:0] idx);
    logic signed [WORD_W-1:0] half;
    half = $signed(idx) >>> 1;
    return base + WORD_W'(half);
  endfunction

  // Pull one lane out of a word: odd lane = low half, even lane = high half.
  function automatic logic [BYTE_W-1:0] lane_get(input logic [WORD_W-1:0] w,
                                                 input logic odd);
    return odd ? w[BYTE_W-1:0] : w[WORD_W-1:BYTE_W];
  endfunction

  // Replace one lane of a word, keeping the other.
  function automatic logic [WORD_W-1:0] lane_put(input logic [WORD_W-1:0] w,
                                                 input logic odd,
                                                 input logic [BYTE_W-1:0] b);
    return odd ? {w[WORD_W-1:BYTE_W], b} : {b, w[BYTE_W-1:0]};
  endfunction
endpackage

// File: rtl/bau_addr_gen.sv
module bau_addr_gen
  import bau_pkg::*;
(
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  input  logic              swap_ops,
  output logic [WORD_W-1:0] word_addr,
  output logic              lane_odd
);
  logic [WORD_W-1:0] base_sel;
  logic [WORD_W-1:0] index_sel;

  assign base_sel  = swap_ops ? opnd_b : opnd_a;
  assign index_sel = swap_ops ? opnd_a : opnd_b;
  assign word_addr = word_of(base_sel, index_sel);
  assign lane_odd  = index_sel[0];

  // R1
  always_comb begin
    addr_step_chk: assert (($signed(word_addr - base_sel) == ($signed(index_sel) >>> 1)));
  end
endmodule

// File: rtl/bau_lane.sv
module bau_lane
  import bau_pkg::*;
(
  input  logic [WORD_W-1:0] word_in,
  input  logic              lane_odd,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [WORD_W-1:0] byte_zext,
  output logic [WORD_W-1:0] word_merged
);
  assign byte_zext   = {{(WORD_W-BYTE_W){1'b0}}, lane_get(word_in, lane_odd)};
  assign word_merged = lane_put(word_in, lane_odd, byte_in);

  // R4
  always_comb begin
    keep_other_chk: assert (lane_get(word_merged, ~lane_odd) == lane_get(word_in, ~lane_odd));
  end
endmodule

// File: rtl/bau_ctrl.sv
module bau_ctrl
  import bau_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic op_store,
  output logic accept,
  output logic capture_merge,
  output logic load_done,
  output logic busy,
  output logic done,
  output logic mem_re,
  output logic mem_we
);
  bau_state_t state_q, state_d;
  logic       store_q;

  assign accept = (state_q == ST_IDLE) && start;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_READ;
      ST_READ:  state_d = ST_DATA;
      ST_DATA:  state_d = store_q ? ST_GAP : ST_IDLE;
      ST_GAP:   state_d = ST_WRITE;
      ST_WRITE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      store_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) store_q <= op_store;
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign mem_re        = (state_q == ST_READ);
  assign mem_we        = (state_q == ST_WRITE);
  assign load_done     = (state_q == ST_DATA) && !store_q;
  assign capture_merge = (state_q == ST_DATA) && store_q;
  assign done          = load_done || mem_we;

  // R7
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_re && mem_we));
  // R7
  gap_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (!$past(mem_re) && !$past(mem_we) && $past(mem_re, 3)));
  // R6
  load_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> $past(mem_re));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_re |=> !mem_re);
endmodule

// File: rtl/byte_access_unit.sv
module byte_access_unit
  import bau_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_store,
  input  logic              swap_ops,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] load_data,
  output logic [WORD_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  logic              accept, capture_merge, load_done;
  logic [WORD_W-1:0] addr_calc;
  logic              odd_calc;
  logic [WORD_W-1:0] addr_q;
  logic              odd_q;
  logic [BYTE_W-1:0] byte_q;
  logic [WORD_W-1:0] merged_q;
  logic [WORD_W-1:0] byte_zext, word_merged;

  bau_addr_gen u_addr (
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .swap_ops (swap_ops),
    .word_addr(addr_calc),
    .lane_odd (odd_calc)
  );

  bau_lane u_lane (
    .word_in    (mem_rdata),
    .lane_odd   (odd_q),
    .byte_in    (byte_q),
    .byte_zext  (byte_zext),
    .word_merged(word_merged)
  );

  bau_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .op_store     (op_store),
    .accept       (accept),
    .capture_merge(capture_merge),
    .load_done    (load_done),
    .busy         (busy),
    .done         (done),
    .mem_re       (mem_re),
    .mem_we       (mem_we)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q   <= '0;
      odd_q    <= 1'b0;
      byte_q   <= '0;
      merged_q <= '0;
    end else begin
      if (accept) begin
        addr_q <= addr_calc;
        odd_q  <= odd_calc;
        byte_q <= wr_byte;
      end
      if (capture_merge) merged_q <= word_merged;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = merged_q;
  assign load_data = load_done ? byte_zext : '0;

  // R3
  zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (load_data[WORD_W-1:BYTE_W] == '0));
  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr));
endmodule

// File: tb/byte_access_unit_tb.sv
module byte_access_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_store = 1'b0;
  logic        swap_ops = 1'b0;
  logic [15:0] opnd_a = '0;
  logic [15:0] opnd_b = '0;
  logic [7:0]  wr_byte = '0;
  logic        busy, done, mem_re, mem_we;
  logic [15:0] load_data, mem_addr, mem_wdata;
  logic [15:0] mem_rdata;
  logic [15:0] mem [0:63];

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  byte_access_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_store(op_store),
    .swap_ops(swap_ops), .opnd_a(opnd_a), .opnd_b(opnd_b), .wr_byte(wr_byte),
    .busy(busy), .done(done), .load_data(load_data), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[5:0]];
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_addr(input logic [15:0] base, input int idx);
    int q;
    q = (idx >= 0) ? idx / 2 : -((-idx + 1) / 2);
    return base + 16'(q);
  endfunction

  // One operation; intrude pulses start mid-operation with other operands.
  task automatic run_op(input bit st, input bit sw, input logic [15:0] base, input int idx,
                        input logic [7:0] d, input bit intrude);
    logic [15:0] ea, old, expw;
    bit odd;
    ea  = exp_addr(base, idx);
    odd = idx[0];
    @(negedge clk);
    op_store = st; swap_ops = sw; wr_byte = d;
    if (sw) begin opnd_a = 16'(idx); opnd_b = base; end
    else    begin opnd_a = base;     opnd_b = 16'(idx); end
    start = 1'b1;
    @(negedge clk);
    start = intrude;
    if (intrude) begin opnd_a = ~opnd_a; opnd_b = opnd_b + 16'd7; op_store = ~st; end
    chk(mem_re == 1'b1 && done == 1'b0, "R6", {15'd0, mem_re}, 16'd1);
    chk(mem_addr == ea, "R1/R5", mem_addr, ea);
    old = mem[ea[5:0]];
    @(negedge clk);
    start = 1'b0;
    if (!st) begin
      chk(done == 1'b1, "R6", {15'd0, done}, 16'd1);
      expw = {8'h00, odd ? old[7:0] : old[15:8]};
      chk(load_data == expw, odd ? "R2/R3 odd" : "R2/R3 even", load_data, expw);
    end else begin
      chk(done == 1'b0 && mem_we == 1'b0, "R7", {done, mem_we}, 16'd0);
      @(negedge clk);
      chk(mem_re == 1'b0 && mem_we == 1'b0 && busy == 1'b1, "R7 gap", {mem_re, mem_we}, 16'd0);
      @(negedge clk);
      expw = odd ? {old[15:8], d} : {d, old[7:0]};
      chk(mem_we == 1'b1 && done == 1'b1 && mem_re == 1'b0, "R7", {mem_we, done}, 16'd3);
      chk(mem_addr == ea, "R1", mem_addr, ea);
      chk(mem_wdata == expw, "R4", mem_wdata, expw);
    end
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0 && mem_re == 1'b0, "R8/R9", {done, busy, mem_re}, 16'd0);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h1357) ^ 16'hA5C3;
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && mem_re == 0 && mem_we == 0, "R9 reset",
        {busy, done, mem_re, mem_we}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && mem_re == 0, "R9 idle", {busy, mem_re}, 16'd0);
    for (int sw = 0; sw < 2; sw++) begin
      for (int bi = 0; bi < 3; bi++) begin
        for (int idx = -6; idx <= 6; idx++) begin
          logic [15:0] b;
          logic [7:0] d;
          b = (bi == 0) ? 16'd8 : (bi == 1) ? 16'd20 : 16'd33;
          d = 8'(idx * 37 + bi * 11 + sw * 90) ^ 8'h5A;
          run_op(1'b0, sw[0], b, idx, 8'h00, 1'b0);
          run_op(1'b1, sw[0], b, idx, d, (idx == 3));
          run_op(1'b0, sw[0], b, idx, 8'h00, (idx == -3));
          run_op(1'b0, sw[0], b, idx ^ 1, 8'h00, 1'b0);
        end
      end
    end
    // Wrap cases (R1)
    run_op(1'b0, 1'b0, 16'h0000, -1, 8'h00, 1'b0);
    run_op(1'b0, 1'b1, 16'h0000, -4, 8'h00, 1'b0);
    run_op(1'b1, 1'b0, 16'hFFFF, 2, 8'hC3, 1'b0);
    run_op(1'b0, 1'b0, 16'hFFFF, 3, 8'h00, 1'b0);
    run_op(1'b0, 1'b1, 16'h8000, -32767, 8'h00, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule